// File: doc/BRIEF.md
# Iterative RC5 Encryption Core

This block encrypts a single block of two `WORD_W`-bit words with the RC5 round structure: a key pre-whitening step followed by `ROUNDS` full rounds, each round mixing the two halves with XOR, a data-dependent left rotation and a modular addition of a round key. One round is finished every clock cycle, so one block needs `ROUNDS + 1` cycles from the accepted message write to the result.

Before use, a host loads the `2*ROUNDS + 2` round keys one at a time through an index/value/strobe port. The keys land in two separate banks, one holding even-numbered keys and one holding odd-numbered keys, so that each round can read both of its keys in the same cycle while each bank still serves only one location per cycle. Writing a message then starts the encryption at once. When the last round finishes, a one-cycle `done` pulse appears and the ciphertext output takes the new value, which it keeps until the next block completes.

Top module: `rc5_iter_core`

## Requirements
- R1: A key write with strobe `key_we` stores `key_val` as round key number `key_idx`. Bit 0 of `key_idx` picks the bank (0 = even bank, 1 = odd bank), and `key_idx >> 1` is the location inside that bank.
- R2: On an accepted message write, the upper word of `msg` plus key 0 becomes the working word A, and the lower word plus key 1 becomes the working word B, both modulo 2^WORD_W.
- R3: Round j (1..ROUNDS) forms A' = rotl(A xor B, B mod WORD_W) + key 2j, then B' = rotl(B xor A', A' mod WORD_W) + key 2j+1, and stores both in the same clock edge.
- R4: The ciphertext `ct` is A in bits [2*WORD_W-1:WORD_W] and B in bits [WORD_W-1:0] after the last round.
- R5: If a message write is sampled at clock edge n, `done` is high from edge n+ROUNDS and `ct` carries the new result from that same edge.
- R6: `done` is high for exactly one cycle per encryption.
- R7: `ct` keeps its value in every cycle in which no encryption completes.
- R8: After reset, `done` is low and `ct` reads zero until the first encryption completes.
- R9: A message write while an encryption is in progress is ignored: no extra completion, and the running result is unchanged.
- R10: Different key values or a different message give the result defined by R2 and R3; rewriting a single key changes only that key's contribution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| key_we | input | 1 | Round key write strobe |
| key_idx | input | clog2(2*ROUNDS+2) | Round key number |
| key_val | input | WORD_W | Round key value |
| msg_we | input | 1 | Message write strobe, starts encryption when idle |
| msg | input | 2*WORD_W | Plaintext block, word A in the upper half |
| done | output | 1 | One-cycle completion pulse |
| ct | output | 2*WORD_W | Ciphertext, held until the next completion |

## Verification
The assertions assume that reset is held for at least one clock edge before anything else happens and that the key banks are fully written before the first message arrives; they also assume keys are not rewritten during a running encryption. The bench loads all keys while the core is idle, only starts a message after the previous `done` pulse, and confines key rewrites to idle gaps, while the one deliberate mid-run message write exercises the ignore rule without touching keys.

// File: rtl/rc5_core_pkg.sv
package rc5_core_pkg;

    // Width of an index able to address n items, never below one bit.
    function automatic int unsigned idx_w(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

endpackage

// File: rtl/rc5_key_bank.sv
module rc5_key_bank #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned DEPTH  = 4,
    localparam int unsigned AW    = rc5_core_pkg::idx_w(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (waddr <= LAST)) begin
            mem[waddr] <= wdata;
        end
    end

    // One read location per cycle, asynchronous.
    always_comb begin
        rdata = '0;
        if (raddr <= LAST) begin
            rdata = mem[raddr];
        end
    end

endmodule

// File: rtl/rc5_round.sv
module rc5_round #(
    parameter int unsigned WORD_W = 16,
    localparam int unsigned SH_W  = rc5_core_pkg::idx_w(WORD_W)
) (
    input  logic [WORD_W-1:0] a_in,
    input  logic [WORD_W-1:0] b_in,
    input  logic [WORD_W-1:0] k_even,
    input  logic [WORD_W-1:0] k_odd,
    output logic [WORD_W-1:0] a_out,
    output logic [WORD_W-1:0] b_out
);
    function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] x,
                                                input logic [SH_W-1:0]   amt);
        logic [2*WORD_W-1:0] dbl;
        dbl = {x, x} << amt;
        return dbl[2*WORD_W-1:WORD_W];
    endfunction

    logic [WORD_W-1:0] mix_a;
    logic [WORD_W-1:0] mix_b;

    always_comb begin
        mix_a = rotl(a_in ^ b_in, b_in[SH_W-1:0]);
        a_out = mix_a + k_even;
        mix_b = rotl(b_in ^ a_out, a_out[SH_W-1:0]);
        b_out = mix_b + k_odd;
    end

endmodule

// File: rtl/rc5_sequencer.sv
module rc5_sequencer #(
    parameter int unsigned ROUNDS = 3,
    localparam int unsigned AW    = rc5_core_pkg::idx_w(ROUNDS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_req,
    output logic          load,
    output logic          busy,
    output logic          last,
    output logic [AW-1:0] rnd,
    output logic          done
);
    import rc5_core_pkg::*;

    localparam logic [AW-1:0] FINAL = AW'(ROUNDS);

    phase_e        phase_q;
    logic [AW-1:0] rnd_q;
    logic          done_q;

    assign busy = (phase_q == PH_RUN);
    assign load = !busy && start_req;
    assign last = busy && (rnd_q == FINAL);
    assign rnd  = rnd_q;
    assign done = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            rnd_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load) begin
                phase_q <= PH_RUN;
                rnd_q   <= AW'(1);
            end else if (busy) begin
                if (last) begin
                    phase_q <= PH_IDLE;
                    rnd_q   <= '0;
                    done_q  <= 1'b1;
                end else begin
                    rnd_q <= rnd_q + AW'(1);
                end
            end
        end
    end

    // R5: an accepted write leads straight into round one
    a_r5_start: assert property (@(posedge clk) disable iff (rst)
        load |=> busy && (rnd == AW'(1)));

    // R5: completion only comes out of a running encryption
    a_r5_done_after_run: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

    // R6: completion pulse lasts one cycle
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: a running encryption advances one round per cycle whatever start_req does
    a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy && !last) |=> busy && (rnd == $past(rnd) + AW'(1)));

endmodule

// File: rtl/rc5_iter_core.sv
module rc5_iter_core #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned ROUNDS = 3,
    localparam int unsigned NKEYS = 2 * ROUNDS + 2,
    localparam int unsigned KIW   = rc5_core_pkg::idx_w(NKEYS),
    localparam int unsigned DEPTH = ROUNDS + 1,
    localparam int unsigned AW    = rc5_core_pkg::idx_w(DEPTH)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                key_we,
    input  logic [KIW-1:0]      key_idx,
    input  logic [WORD_W-1:0]   key_val,
    input  logic                msg_we,
    input  logic [2*WORD_W-1:0] msg,
    output logic                done,
    output logic [2*WORD_W-1:0] ct
);
    typedef struct packed {
        logic [WORD_W-1:0] a;
        logic [WORD_W-1:0] b;
    } pair_t;

    logic              load;
    logic              busy;
    logic              last;
    logic [AW-1:0]     rnd;
    logic [AW-1:0]     rd_addr;
    logic [WORD_W-1:0] bank_rd [2];
    pair_t             work_q;
    pair_t             next_w;
    pair_t             msg_w;
    pair_t             ct_q;

    assign msg_w   = pair_t'(msg);
    assign rd_addr = busy ? rnd : '0;

    rc5_sequencer #(.ROUNDS(ROUNDS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_req (msg_we),
        .load      (load),
        .busy      (busy),
        .last      (last),
        .rnd       (rnd),
        .done      (done)
    );

    // Even keys in bank 0, odd keys in bank 1, both addressed by idx/2.
    for (genvar p = 0; p < 2; p++) begin : g_bank
        rc5_key_bank #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_bank (
            .clk   (clk),
            .we    (key_we && (key_idx[0] == 1'(p))),
            .waddr (key_idx[KIW-1:1]),
            .wdata (key_val),
            .raddr (rd_addr),
            .rdata (bank_rd[p])
        );
    end

    rc5_round #(.WORD_W(WORD_W)) u_round (
        .a_in   (work_q.a),
        .b_in   (work_q.b),
        .k_even (bank_rd[0]),
        .k_odd  (bank_rd[1]),
        .a_out  (next_w.a),
        .b_out  (next_w.b)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            work_q <= '0;
            ct_q   <= '0;
        end else if (load) begin
            work_q.a <= msg_w.a + bank_rd[0];
            work_q.b <= msg_w.b + bank_rd[1];
        end else if (busy) begin
            work_q <= next_w;
            if (last) begin
                ct_q <= next_w;
            end
        end
    end

    assign ct = ct_q;

    // Assertion-only history of whether any block has completed.
    logic done_seen_q;
    always_ff @(posedge clk) begin
        if (rst)       done_seen_q <= 1'b0;
        else if (done) done_seen_q <= 1'b1;
    end

    // R7: output only moves in the cycle of a completion
    a_r7_ct_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(ct));

    // R8: zero output until the first completion
    a_r8_ct_zero: assert property (@(posedge clk) disable iff (rst)
        (!done_seen_q && !done) |-> (ct == '0));

endmodule

// File: tb/sim_rc5_iter_core.sv
module sim_rc5_iter_core;
    localparam int unsigned W     = 16;
    localparam int unsigned R     = 3;
    localparam int unsigned NK    = 2 * R + 2;
    localparam int unsigned KIW   = $clog2(NK);

    typedef struct {
        logic [2*W-1:0] val;
        int             due;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             key_we = 1'b0;
    logic [KIW-1:0]   key_idx = '0;
    logic [W-1:0]     key_val = '0;
    logic             msg_we = 1'b0;
    logic [2*W-1:0]   msg = '0;
    logic             done;
    logic [2*W-1:0]   ct;

    logic [W-1:0]     keys [NK];
    exp_t             sb [$];
    int               cyc = 0;
    int               n_chk = 0;
    int               n_bad = 0;
    logic             prev_done = 1'b0;
    logic [2*W-1:0]   last_ct = '0;

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    rc5_iter_core #(.WORD_W(W), .ROUNDS(R)) u0 (
        .clk(clk), .rst(rst), .key_we(key_we), .key_idx(key_idx),
        .key_val(key_val), .msg_we(msg_we), .msg(msg), .done(done), .ct(ct)
    );

    function automatic logic [W-1:0] rotl(input logic [W-1:0] x, input int amt);
        logic [W-1:0] r;
        r = x;
        for (int s = 0; s < amt % W; s++) r = {r[W-2:0], r[W-1]};
        return r;
    endfunction

    // R2, R3, R4 reference
    function automatic logic [2*W-1:0] ref_enc(input logic [2*W-1:0] m);
        logic [W-1:0] a, b;
        a = m[2*W-1:W] + keys[0];
        b = m[W-1:0] + keys[1];
        for (int j = 1; j <= R; j++) begin
            a = rotl(a ^ b, int'(b)) + keys[2*j];
            b = rotl(b ^ a, int'(a)) + keys[2*j+1];
        end
        return {a, b};
    endfunction

    task automatic check(input string req, input logic [2*W-1:0] got,
                         input logic [2*W-1:0] want);
        n_chk++;
        if (got !== want) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, got, want);
        end
    endtask

    task automatic write_key(input int i, input logic [W-1:0] v);
        @(negedge clk);
        key_we  <= 1'b1;
        key_idx <= KIW'(i);
        key_val <= v;
        keys[i] = v;
        @(negedge clk);
        key_we  <= 1'b0;
    endtask

    // Driver: one message while idle, expected result queued for the monitor.
    task automatic send(input logic [2*W-1:0] m);
        exp_t e;
        @(negedge clk);
        msg    <= m;
        msg_we <= 1'b1;
        e.val  = ref_enc(m);
        e.due  = cyc + 1 + R;          // R5: edge n+R after sampling edge n
        sb.push_back(e);
        @(negedge clk);
        msg_we <= 1'b0;
    endtask

    task automatic drain();
        for (int t = 0; t < 50 && sb.size() != 0; t++) @(negedge clk);
        if (sb.size() != 0) check("R5", 32'd0, 32'd1);
    endtask

    // Monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (done && prev_done) check("R6", {31'd0, done}, 32'd0);
            if (done) begin
                if (sb.size() == 0) begin
                    check("R9", 32'd1, 32'd0);  // completion nobody started
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check("R3/R4", ct, e.val);
                    check("R5", 32'(cyc), 32'(e.due));
                    last_ct = ct;
                end
            end
            prev_done = done;
        end
    end

    initial begin
        #(20 * 20000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [2*W-1:0] m;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R8", ct, '0);
        check("R8", {31'd0, done}, 32'd0);

        // R1: load keys through both banks
        for (int i = 0; i < NK; i++) write_key(i, W'(i * 16'h3C5B + 16'h0F17));

        // R8: output stays zero while the first block is running
        send(32'h1234_5678);
        check("R8", ct, '0);
        @(negedge clk);
        check("R8", ct, '0);
        drain();

        // R2/R3: assorted patterns, including words with upper bits set
        send(32'h0000_0000); drain();
        send(32'hFFFF_FFFF); drain();
        send(32'h8000_0001); drain();
        send(32'hDEAD_BEEF); drain();
        m = 32'hACE1_5A3C;
        for (int k = 0; k < 6; k++) begin
            m = {m[30:0], m[31] ^ m[21] ^ m[1] ^ m[0]} ^ 32'(k * 32'h0101_0101);
            send(m);
            drain();
        end

        // R7: output holds across idle cycles
        repeat (7) @(negedge clk);
        check("R7", ct, last_ct);

        // R1/R10: rewrite one even and one odd key
        write_key(2, 16'h0000);
        write_key(5, 16'hFFFF);
        send(32'hDEAD_BEEF); drain();

        // R9: a second write during the run is ignored
        send(32'h0F0F_F0F0);
        @(negedge clk);
        msg    <= 32'h5555_AAAA;
        msg_we <= 1'b1;
        @(negedge clk);
        msg_we <= 1'b0;
        drain();
        repeat (R + 3) @(negedge clk);
        check("R9", ct, last_ct);
        check("R7", {31'd0, done}, 32'd0);

        // R5: back-to-back, next block starts right after the pulse
        send(32'h0BAD_F00D);
        drain();
        send(32'h1357_9BDF);
        drain();

        // R8: reset clears the output again
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        prev_done = 1'b0;
        @(negedge clk);
        check("R8", ct, '0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule